// File: doc/BRIEF.md
# Receiver Polling and Sleep Sequencer

This block sets the operating mode of a low-power radio receiver. When left to itself, it runs a polling loop. It sleeps for a programmed number of prescaled ticks, wakes through a start-up phase of programmable length, and then enables an external bit checker. If the bit check passes, the block moves into receiving mode and hands control to the clock-recovery logic. If the bit check fails, the block returns to sleep. Inside receiving mode, a clock-recovery error sends the block back to hunting for a valid bit pattern, and the block stays in receiving mode while it does so.

An active-low, level-sensitive override pin lets a host take direct control. While the pin is low, the block wakes from sleep whatever sleep code is stored, then proceeds to receiving mode. The stored sleep code is kept but has no effect. A fixed number of cycles after the pin returns high, the block drops back into sleep and resumes the polling loop with the stored code. The all-ones sleep code means permanent sleep, which only the override can end.

The internal states are SLEEP, WAKE (start-up), POLL (bit check), RX_HUNT and RX_LOCK. The transitions are:
- SLEEP→WAKE, on override or when the sleep count expires.
- WAKE→POLL or WAKE→RX_HUNT, when the start-up count expires.
- POLL→RX_LOCK on a pass, POLL→SLEEP on a fail, and POLL→RX_HUNT on override.
- RX_HUNT→RX_LOCK on a pass.
- RX_LOCK→RX_HUNT on a clock-recovery error.
- any state→SLEEP when the override release delay ends.

Top module: `rx_mode_seq`

## Requirements
- R1: While reset is asserted, `mode` is 0 (sleep) and both enables are low. The stored sleep code resets to 31, so the block stays asleep after reset until it is written or overridden.
- R2: `mode` encodes sleep=0, start-up=1, bit-check=2 and receiving=3. `chk_en` is high in bit-check and in receiving while hunting. `clkrec_en` is high only in receiving while locked, and never together with `chk_en`.
- R3: A stored sleep code c other than 31 keeps the block in sleep for c×TICK_DIV+1 cycles after the cycle it enters sleep; the next cycle is start-up. A write while the block is in permanent sleep restarts the count from the new code.
- R4: With code 31 stored and `ovr_n` high, the block stays in sleep indefinitely.
- R5: Start-up lasts `wake_cycles`+1 cycles. With the override inactive, bit-check follows.
- R6: A `chk_done` strobe with `chk_pass`=1 in bit-check makes the next cycle receiving-locked.
- R7: A `chk_done` strobe with `chk_pass`=0 in bit-check makes the next cycle sleep, with the sleep count reloaded from the stored code.
- R8: When `ovr_n` is low in sleep, the next cycle is start-up whatever code is stored. If the override is still in effect when start-up ends, the block enters receiving-hunt. When `ovr_n` is low in bit-check, the next cycle is receiving-hunt.
- R9: A sleep-code write while the override is in effect leaves the mode unchanged, and the block keeps the written code. After release, the sleep duration follows that code.
- R10: Counting the first cycle with `ovr_n` sampled high as cycle 1, the block enters sleep at cycle REL_DLY. The sleep count is loaded from the stored code.
- R11: A `clkrec_err` in receiving-locked gives receiving-hunt on the next cycle, and `mode` stays 3. A failed check in receiving-hunt stays in receiving-hunt. A passed check in receiving-hunt returns to locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_n | input | 1 | Active-low override; low forces wake-up and receiving |
| cfg_wr | input | 1 | Write strobe for the stored sleep code |
| cfg_sleep | input | SLEEP_W | Sleep code to store; all ones means permanent sleep |
| wake_cycles | input | WAKE_W | Start-up length minus one, in clock cycles |
| chk_done | input | 1 | Bit-check result strobe |
| chk_pass | input | 1 | Bit-check result, valid with `chk_done` |
| clkrec_err | input | 1 | Clock-recovery error flag |
| mode | output | 2 | Current mode (0 sleep, 1 start-up, 2 bit-check, 3 receiving) |
| chk_en | output | 1 | Enable for the bit checker |
| clkrec_en | output | 1 | Enable for the clock-recovery logic |

## Verification
Every strobe (`chk_done`, `clkrec_err`, `ovr_n` falling) changes the outputs on the first clock edge that samples it. Start-up ends `wake_cycles`+1 edges after entry. Sleep ends c×TICK_DIV+1 edges after entry. A release reaches sleep on the REL_DLY-th edge that samples `ovr_n` high. The bench turns each of these counts into an absolute cycle stamp when it applies the stimulus, and queues the stamp with the expected mode and enables. A monitor compares each queued item a quarter period after the matching rising edge, and it also samples the cycle just before each boundary, so that a result that arrives early or late is caught.

// File: rtl/rx_mode_pkg.sv
package rx_mode_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_POLL,
        ST_RX_HUNT,
        ST_RX_LOCK
    } seq_state_e;

    localparam logic [1:0] MODE_SLEEP = 2'd0;
    localparam logic [1:0] MODE_WAKE  = 2'd1;
    localparam logic [1:0] MODE_POLL  = 2'd2;
    localparam logic [1:0] MODE_RX    = 2'd3;

endpackage

// File: rtl/rx_down_timer.sv
// Loadable down-counter with an optional tick prescaler.
// With DIV > 1 the count drops once every DIV cycles of run; with DIV == 1 every cycle.
module rx_down_timer #(
    parameter int W   = 5,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt_q;
    logic         step;

    generate
        if (DIV > 1) begin : g_pre
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;
            logic          tick;

            assign tick = (pre_q == PW'(DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (load) begin
                    pre_q <= '0;
                end else if (run && (cnt_q != '0)) begin
                    pre_q <= tick ? '0 : pre_q + 1'b1;
                end
            end

            assign step = tick;
        end else begin : g_nopre
            assign step = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0) && step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rx_release_det.sv
// Tracks the override: hold is set while ovr_n is low and stays set through
// DLY cycles of ovr_n high; fire marks the cycle in which the hold ends.
module rx_release_det #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_n,
    output logic hold,
    output logic fire
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(DLY - 1));
    assign fire = hold && ovr_n && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= 1'b0;
            cnt_q <= '0;
        end else if (!ovr_n) begin
            hold  <= 1'b1;
            cnt_q <= '0;
        end else if (hold) begin
            if (last) begin
                hold  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_mode_seq.sv
module rx_mode_seq
    import rx_mode_pkg::*;
#(
    parameter int SLEEP_W  = 5,
    parameter int TICK_DIV = 4,
    parameter int WAKE_W   = 8,
    parameter int REL_DLY  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovr_n,
    input  logic               cfg_wr,
    input  logic [SLEEP_W-1:0] cfg_sleep,
    input  logic [WAKE_W-1:0]  wake_cycles,
    input  logic               chk_done,
    input  logic               chk_pass,
    input  logic               clkrec_err,
    output logic [1:0]         mode,
    output logic               chk_en,
    output logic               clkrec_en
);
    localparam logic [SLEEP_W-1:0] PERM_CODE = '1;

    seq_state_e         state_q, state_d;
    logic [SLEEP_W-1:0] sleep_reg_q;
    logic [SLEEP_W-1:0] sleep_src;
    logic               perm;
    logic               hold, rel_fire, ovr_act;
    logic               slp_load, slp_zero;
    logic               wake_load, wake_zero;

    // stored sleep code; kept across any override
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_reg_q <= PERM_CODE;
        end else if (cfg_wr) begin
            sleep_reg_q <= cfg_sleep;
        end
    end

    assign sleep_src = cfg_wr ? cfg_sleep : sleep_reg_q;
    assign perm      = (sleep_reg_q == PERM_CODE);
    assign ovr_act   = hold || !ovr_n;

    rx_release_det #(.DLY(REL_DLY)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .ovr_n (ovr_n),
        .hold  (hold),
        .fire  (rel_fire)
    );

    rx_down_timer #(.W(SLEEP_W), .DIV(TICK_DIV)) u_sleep_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slp_load),
        .load_val (sleep_src),
        .run      (state_q == ST_SLEEP && !perm),
        .zero     (slp_zero)
    );

    rx_down_timer #(.W(WAKE_W), .DIV(1)) u_wake_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (wake_cycles),
        .run      (state_q == ST_WAKE),
        .zero     (wake_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rel_fire) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    if (ovr_act || (!perm && slp_zero)) state_d = ST_WAKE;
                end
                ST_WAKE: begin
                    if (wake_zero) state_d = ovr_act ? ST_RX_HUNT : ST_POLL;
                end
                ST_POLL: begin
                    if (ovr_act)       state_d = ST_RX_HUNT;
                    else if (chk_done) state_d = chk_pass ? ST_RX_LOCK : ST_SLEEP;
                end
                ST_RX_HUNT: begin
                    if (chk_done && chk_pass) state_d = ST_RX_LOCK;
                end
                ST_RX_LOCK: begin
                    if (clkrec_err) state_d = ST_RX_HUNT;
                end
                default: state_d = ST_SLEEP;
            endcase
        end
    end

    assign slp_load  = (state_d == ST_SLEEP) && ((state_q != ST_SLEEP) || rel_fire || perm);
    assign wake_load = (state_d == ST_WAKE) && (state_q != ST_WAKE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mode      = MODE_SLEEP;
        chk_en    = 1'b0;
        clkrec_en = 1'b0;
        unique case (state_q)
            ST_SLEEP:   mode = MODE_SLEEP;
            ST_WAKE:    mode = MODE_WAKE;
            ST_POLL:    begin mode = MODE_POLL; chk_en = 1'b1; end
            ST_RX_HUNT: begin mode = MODE_RX;   chk_en = 1'b1; end
            ST_RX_LOCK: begin mode = MODE_RX;   clkrec_en = 1'b1; end
            default:    mode = MODE_SLEEP;
        endcase
    end
endmodule

// File: rtl/rx_mode_seq_chk.sv
module rx_mode_seq_chk #(
    parameter int SLEEP_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ovr_n,
    input logic               cfg_wr,
    input logic               chk_done,
    input logic               chk_pass,
    input logic               clkrec_err,
    input logic [1:0]         mode,
    input logic               chk_en,
    input logic               clkrec_en,
    input logic [SLEEP_W-1:0] sleep_reg,
    input logic               rel_fire
);
    localparam logic [SLEEP_W-1:0] PERM = '1;

    assert_enables_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_en && clkrec_en));

    assert_lock_only_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clkrec_en |-> (mode == 2'd3));

    assert_perm_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && sleep_reg == PERM && ovr_n && !cfg_wr && !rel_fire) |=> (mode == 2'd0));

    assert_pass_to_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && chk_done && chk_pass && ovr_n && !rel_fire) |=> (mode == 2'd3 && clkrec_en));

    assert_fail_to_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && chk_done && !chk_pass && ovr_n && !rel_fire) |=> (mode == 2'd0));

    assert_override_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !ovr_n) |=> (mode == 2'd1));

    assert_release_sleeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fire |=> (mode == 2'd0));

    assert_err_rehunt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clkrec_en && clkrec_err && !rel_fire) |=> (mode == 2'd3 && chk_en && !clkrec_en));
endmodule

bind rx_mode_seq rx_mode_seq_chk #(.SLEEP_W(SLEEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_n      (ovr_n),
    .cfg_wr     (cfg_wr),
    .chk_done   (chk_done),
    .chk_pass   (chk_pass),
    .clkrec_err (clkrec_err),
    .mode       (mode),
    .chk_en     (chk_en),
    .clkrec_en  (clkrec_en),
    .sleep_reg  (sleep_reg_q),
    .rel_fire   (rel_fire)
);

// File: tb/sim_rx_mode_seq.sv
module sim_rx_mode_seq;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovr_n = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_sleep = '0;
    logic [7:0] wake_cycles = 8'd3;
    logic       chk_done = 1'b0;
    logic       chk_pass = 1'b0;
    logic       clkrec_err = 1'b0;
    logic [1:0] mode;
    logic       chk_en, clkrec_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int         q_cyc[$];
    logic [3:0] q_val[$];
    string      q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    rx_mode_seq #(.SLEEP_W(5), .TICK_DIV(4), .WAKE_W(8), .REL_DLY(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ovr_n(ovr_n), .cfg_wr(cfg_wr), .cfg_sleep(cfg_sleep),
        .wake_cycles(wake_cycles), .chk_done(chk_done), .chk_pass(chk_pass),
        .clkrec_err(clkrec_err), .mode(mode), .chk_en(chk_en), .clkrec_en(clkrec_en)
    );

    // driver side: queue an expectation d cycles ahead
    task automatic expect_at(input int d, input logic [1:0] m, input logic ce,
                             input logic re, input string tag);
        q_cyc.push_back(cyc + d);
        q_val.push_back({m, ce, re});
        q_tag.push_back(tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ovr_n = 1'b1;
        cfg_wr = 1'b0;
        chk_done = 1'b0;
        clkrec_err = 1'b0;
        @(negedge clk);
        expect_at(1, 2'd0, 1'b0, 1'b0, "R1");
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // monitor: compare queued items a quarter period after each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #(CLK_P/4);
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            int         c;
            logic [3:0] v, act;
            string      t;
            c = q_cyc.pop_front();
            v = q_val.pop_front();
            t = q_tag.pop_front();
            act = {mode, chk_en, clkrec_en};
            checks++;
            if (c != cyc || act !== v) begin
                errors++;
                $display("FAIL %s cycle %0d: mode/chk_en/clkrec_en actual %b expected %b",
                         t, c, act, v);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Scenario A: polling loop, R1 R3 R5 R7 R6 R11 R2
        do_reset();
        expect_at(1, 2'd0, 1'b0, 1'b0, "R1");
        step(1);
        cfg_wr = 1'b1; cfg_sleep = 5'd2;
        expect_at(9,  2'd0, 1'b0, 1'b0, "R3");
        expect_at(10, 2'd1, 1'b0, 1'b0, "R3");
        expect_at(13, 2'd1, 1'b0, 1'b0, "R5");
        expect_at(14, 2'd2, 1'b1, 1'b0, "R5");
        step(1); cfg_wr = 1'b0; step(13);
        chk_done = 1'b1; chk_pass = 1'b0;
        expect_at(1,  2'd0, 1'b0, 1'b0, "R7");
        expect_at(9,  2'd0, 1'b0, 1'b0, "R7");
        expect_at(10, 2'd1, 1'b0, 1'b0, "R7");
        expect_at(14, 2'd2, 1'b1, 1'b0, "R2");
        step(1); chk_done = 1'b0; step(13);
        chk_done = 1'b1; chk_pass = 1'b1;
        expect_at(1, 2'd3, 1'b0, 1'b1, "R6");
        step(1); chk_done = 1'b0;
        expect_at(3, 2'd3, 1'b0, 1'b1, "R6");
        step(3);
        clkrec_err = 1'b1;
        expect_at(1, 2'd3, 1'b1, 1'b0, "R11");
        step(1); clkrec_err = 1'b0;
        expect_at(2, 2'd3, 1'b1, 1'b0, "R11");
        step(2);
        chk_done = 1'b1; chk_pass = 1'b0;
        expect_at(1, 2'd3, 1'b1, 1'b0, "R11");
        step(1);
        chk_pass = 1'b1;
        expect_at(1, 2'd3, 1'b0, 1'b1, "R11");
        step(1); chk_done = 1'b0; step(2);

        // Scenario B: permanent sleep and override, R4 R8 R9 R10
        do_reset();
        expect_at(1,  2'd0, 1'b0, 1'b0, "R4");
        expect_at(30, 2'd0, 1'b0, 1'b0, "R4");
        step(30);
        ovr_n = 1'b0;
        expect_at(1, 2'd1, 1'b0, 1'b0, "R8");
        expect_at(4, 2'd1, 1'b0, 1'b0, "R8");
        expect_at(5, 2'd3, 1'b1, 1'b0, "R8");
        step(6);
        cfg_wr = 1'b1; cfg_sleep = 5'd1;
        expect_at(1, 2'd3, 1'b1, 1'b0, "R9");
        step(1); cfg_wr = 1'b0;
        expect_at(3, 2'd3, 1'b1, 1'b0, "R9");
        step(3);
        ovr_n = 1'b1;
        expect_at(3,  2'd3, 1'b1, 1'b0, "R10");
        expect_at(4,  2'd0, 1'b0, 1'b0, "R10");
        expect_at(8,  2'd0, 1'b0, 1'b0, "R9");
        expect_at(9,  2'd1, 1'b0, 1'b0, "R9");
        expect_at(13, 2'd2, 1'b1, 1'b0, "R9");
        step(13);
        ovr_n = 1'b0;
        expect_at(1, 2'd3, 1'b1, 1'b0, "R8");
        step(1);
        chk_done = 1'b1; chk_pass = 1'b1;
        expect_at(1, 2'd3, 1'b0, 1'b1, "R8");
        step(1); chk_done = 1'b0; step(2);
        ovr_n = 1'b1;
        expect_at(3, 2'd3, 1'b0, 1'b1, "R10");
        expect_at(4, 2'd0, 1'b0, 1'b0, "R10");
        step(6);

        while (q_cyc.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule